// File: doc/BRIEF.md
# Programmable Card Clock Generator

This block derives the clock that is driven to a memory card from the controller's kernel clock. A clock-control word, written in one cycle, holds a divider field, a launch-edge select bit, a power-saving enable, a flow-control enable, the bus-width code and a double-data-rate flag. A divider value of zero passes the kernel clock straight through. Any other value N produces a card clock of the kernel frequency divided by 2N, with a 50% duty cycle.

Alongside the clock, the block produces two launch strobes in the kernel clock domain. The command and data paths use them to know when to change their outputs. The block also passes the configured bus width and DDR mode to those paths.

The clock is stopped (held low) in three cases: power is not on, power saving is enabled and the bus is idle, or flow control is enabled and the FIFO is not ready. A stop only takes hold during a low phase, so a high pulse is never cut short.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is asserted and after its release with the control word still at zero and power off, card_clk_o, launch_rise_o, launch_fall_o and ddr_o are 0, and bus_width_o is 2'b00.
- R2: With divider field (bits 9:0) equal to 0 and the clock running, card_clk_o is high in every kernel high phase and low in every kernel low phase. launch_fall_o is 1 and launch_rise_o is 0 in every such cycle, regardless of bit 16.
- R3: With divider field N in 1..1023 and the clock running, card_clk_o is high for N kernel cycles and low for N kernel cycles.
- R4: In divided mode with bit 16 clear, launch_rise_o pulses once per card period, in the kernel cycle that ends with the card clock rising, and launch_fall_o stays 0. With bit 16 set, launch_fall_o pulses once per period, in the cycle that ends with the card clock falling, and launch_rise_o stays 0. The two strobes are never high together.
- R5: With bit 12 set and bus_idle_i high, the card clock stops low and no strobe is produced. With bit 12 clear, bus_idle_i has no effect.
- R6: With bit 17 set and fifo_rdy_i low, the card clock stops low. With bit 17 clear, fifo_rdy_i has no effect.
- R7: A stop request that arrives while the card clock is high lets that high phase run its full N cycles, and the clock then stays low.
- R8: A divider value written during a card period takes effect at the start of the next low phase. The high phase in progress keeps the old length.
- R9: While pwr_on_i is low, card_clk_o is low and both strobes are 0 from the second kernel edge onward.
- R10: bus_width_o is 2'b10 when bit 15 is set, else 2'b01 when bit 14 is set, else 2'b00. ddr_o follows bit 18. Both outputs are updated in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the clock-control word |
| cfg_wdata_i | input | 32 | Clock-control word |
| bus_idle_i | input | 1 | Card bus idle indication |
| fifo_rdy_i | input | 1 | FIFO ready for another transfer |
| pwr_on_i | input | 1 | Power state is on |
| card_clk_o | output | 1 | Card bus clock |
| launch_rise_o | output | 1 | Launch strobe for a rising-edge launch |
| launch_fall_o | output | 1 | Launch strobe for a falling-edge launch |
| bus_width_o | output | 2 | Bus width code: 00 one bit, 01 four bits, 10 eight bits |
| ddr_o | output | 1 | Double-data-rate mode |

## Verification
The embedded assertions check the following on every cycle:
- the phase counter stays below the active divider;
- the active divider only changes at a period boundary;
- a high phase is never cut short;
- a stopped clock never rises;
- power-off forces the clock low;
- the strobes are exclusive;
- the width code is legal.

Some properties can only be shown by the bench's scenarios, because they depend on the exact cycle count of whole periods:
- the measured high and low lengths for several divider values, including 1023;
- which strobe fires under each edge select;
- the pass-through waveform between kernel edges;
- the exact split of old and new lengths when the divider is rewritten mid-period.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;
  localparam int DIV_W     = 10;
  localparam int BIT_PSAV  = 12;
  localparam int BIT_W4    = 14;
  localparam int BIT_W8    = 15;
  localparam int BIT_NEG   = 16;
  localparam int BIT_HWFC  = 17;
  localparam int BIT_DDR   = 18;

  typedef enum logic [1:0] {
    BW_1 = 2'b00,
    BW_4 = 2'b01,
    BW_8 = 2'b10
  } bus_width_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             psav;
    logic             neg;
    logic             hwfc;
    logic             ddr;
    bus_width_e       width;
  } ckcfg_t;
endpackage

// File: rtl/ckgen_ctrl_reg.sv
module ckgen_ctrl_reg
  import ckgen_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ckcfg_t           cfg_o
);
  ckcfg_t cfg_q;

  function automatic bus_width_e dec_width(input logic w4, input logic w8);
    if (w8)      return BW_8;
    else if (w4) return BW_4;
    else         return BW_1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.div   <= wdata_i[DIV_W-1:0];
      cfg_q.psav  <= wdata_i[BIT_PSAV];
      cfg_q.neg   <= wdata_i[BIT_NEG];
      cfg_q.hwfc  <= wdata_i[BIT_HWFC];
      cfg_q.ddr   <= wdata_i[BIT_DDR];
      cfg_q.width <= dec_width(wdata_i[BIT_W4], wdata_i[BIT_W8]);
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ckgen_run_ctl.sv
module ckgen_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic bus_idle_i,
  input  logic fifo_rdy_i,
  input  logic psav_i,
  input  logic hwfc_i,
  input  logic bypass_i,
  output logic run_o,
  output logic gate_o
);
  logic gate_q;

  assign run_o = pwr_on_i & ~(psav_i & bus_idle_i) & ~(hwfc_i & ~fifo_rdy_i);

  // enable for pass-through path, captured while the kernel clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= run_o & bypass_i;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/ckgen_divider.sv
module ckgen_divider
  import ckgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_on_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_cfg_i,
  output logic             ph_o,
  output logic             bypass_o,
  output logic             rise_evt_o,
  output logic             fall_evt_o
);
  logic [DIV_W-1:0] cnt_q, div_act_q, div_eff;
  logic             ph_q, boundary, last;

  // period starts with a low phase at count zero
  assign boundary = ~ph_q & (cnt_q == '0);
  assign div_eff  = boundary ? div_cfg_i : div_act_q;
  assign bypass_o = (div_eff == '0);
  assign last     = ({1'b0, cnt_q} + 1'b1) == {1'b0, div_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_act_q <= '0;
    end else if (boundary) begin
      div_act_q <= div_cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!pwr_on_i || bypass_o) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!ph_q) begin
      if (!run_i) begin
        cnt_q <= '0;
      end else if (last) begin
        cnt_q <= '0;
        ph_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (last) begin
        cnt_q <= '0;
        ph_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rise_evt_o = pwr_on_i & ~bypass_o & ~ph_q & run_i & last;
  assign fall_evt_o = pwr_on_i & ph_q & last;
  assign ph_o       = ph_q;

  AST_PWR_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> !ph_q); // R9
  AST_STOP_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph_q && !run_i) |=> !ph_q); // R5
  AST_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q && pwr_on_i && (({1'b0, cnt_q} + 1'b1) != {1'b0, div_act_q})) |=> ph_q); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q || cnt_q != '0) |-> (cnt_q < div_act_q)); // R3
  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q || cnt_q != '0) |=> $stable(div_act_q)); // R8
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import ckgen_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             bus_idle_i,
  input  logic             fifo_rdy_i,
  input  logic             pwr_on_i,
  output logic             card_clk_o,
  output logic             launch_rise_o,
  output logic             launch_fall_o,
  output logic [1:0]       bus_width_o,
  output logic             ddr_o
);
  ckcfg_t cfg;
  logic   run, gate, bypass, ph, rise_evt, fall_evt;

  ckgen_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  ckgen_run_ctl u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .bus_idle_i (bus_idle_i),
    .fifo_rdy_i (fifo_rdy_i),
    .psav_i     (cfg.psav),
    .hwfc_i     (cfg.hwfc),
    .bypass_i   (bypass),
    .run_o      (run),
    .gate_o     (gate)
  );

  ckgen_divider u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .run_i      (run),
    .div_cfg_i  (cfg.div),
    .ph_o       (ph),
    .bypass_o   (bypass),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt)
  );

  // pass-through gate only changes while clk_i is low, divided phase is 0 then
  assign card_clk_o    = ph | (clk_i & gate);
  assign launch_rise_o = rise_evt & ~cfg.neg;
  assign launch_fall_o = (fall_evt & cfg.neg) | gate;
  assign bus_width_o   = cfg.width;
  assign ddr_o         = cfg.ddr;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_rise_o && launch_fall_o)); // R4
  AST_WIDTH_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_width_o != 2'b11); // R10
endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        idle = 1'b0;
  logic        fifo_rdy = 1'b1;
  logic        pwr_on = 1'b0;
  logic        card_clk, l_rise, l_fall, ddr;
  logic [1:0]  bw;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  card_clk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .bus_idle_i(idle), .fifo_rdy_i(fifo_rdy), .pwr_on_i(pwr_on),
    .card_clk_o(card_clk), .launch_rise_o(l_rise), .launch_fall_o(l_fall),
    .bus_width_o(bw), .ddr_o(ddr)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_CFG [NV] = '{
    32'h0000_0001, 32'h0001_0003, 32'h0000_4005,
    32'h0004_8002, 32'h0000_C007, 32'h0000_03FF};
  localparam int V_HI [NV] = '{1, 3, 5, 2, 7, 1023};
  localparam int V_W  [NV] = '{0, 0, 1, 2, 2, 0};
  localparam int V_DD [NV] = '{0, 0, 0, 1, 0, 0};
  localparam int V_RS [NV] = '{1, 0, 1, 1, 1, 1};
  localparam int V_FS [NV] = '{0, 1, 0, 0, 0, 0};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1.25;
  endtask

  task automatic wr(input logic [31:0] v);
    we = 1'b1;
    wdata = v;
    tick();
    we = 1'b0;
  endtask

  task automatic to_rise();
    int g = 0;
    while (card_clk !== 1'b0 && g < 5000) begin tick(); g++; end
    while (card_clk !== 1'b1 && g < 5000) begin tick(); g++; end
  endtask

  task automatic measure(output int hi, output int lo, output int rs, output int fs);
    int g = 0;
    hi = 0; lo = 0; rs = 0; fs = 0;
    to_rise();
    while (card_clk === 1'b1 && g < 5000) begin
      hi++; rs += int'(l_rise); fs += int'(l_fall); tick(); g++;
    end
    while (card_clk === 1'b0 && g < 5000) begin
      lo++; rs += int'(l_rise); fs += int'(l_fall); tick(); g++;
    end
  endtask

  // counts samples where the clock or a strobe is high
  task automatic quiet(input int n, output int act);
    act = 0;
    for (int k = 0; k < n; k++) begin
      if (card_clk !== 1'b0 || l_rise !== 1'b0 || l_fall !== 1'b0) act++;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, lo, rs, fs, a;
    repeat (3) tick();
    check("R1 clk in reset", int'(card_clk), 0);
    check("R1 strobes in reset", int'(l_rise | l_fall), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 clk after reset", int'(card_clk), 0);
    check("R1 width after reset", int'(bw), 0);
    check("R1 ddr after reset", int'(ddr), 0);

    pwr_on = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wr(V_CFG[i]);
      check("R10 width", int'(bw), V_W[i]);
      check("R10 ddr", int'(ddr), V_DD[i]);
      measure(hi, lo, rs, fs);
      measure(hi, lo, rs, fs);
      check("R3 high length", hi, V_HI[i]);
      check("R3 low length", lo, V_HI[i]);
      check("R4 rise strobes", rs, V_RS[i]);
      check("R4 fall strobes", fs, V_FS[i]);
    end

    // R9 power off
    wr(32'd4);
    measure(hi, lo, rs, fs);
    pwr_on = 1'b0;
    tick(); tick();
    quiet(20, a);
    check("R9 power off quiet", a, 0);
    pwr_on = 1'b1;

    // R5 power saving
    wr(32'h0000_1002);
    idle = 1'b1;
    repeat (8) tick();
    quiet(20, a);
    check("R5 idle stops clock", a, 0);
    idle = 1'b0;
    measure(hi, lo, rs, fs);
    check("R5 resume high", hi, 2);
    wr(32'd2);
    idle = 1'b1;
    measure(hi, lo, rs, fs);
    check("R5 idle ignored without enable", hi, 2);
    idle = 1'b0;

    // R2 pass-through
    wr(32'd0);
    repeat (6) tick();
    check("R2 high in kernel high", int'(card_clk), 1);
    @(negedge clk); #1.25;
    check("R2 low in kernel low", int'(card_clk), 0);
    tick();
    a = 0;
    for (int k = 0; k < 10; k++) begin
      if (l_fall !== 1'b1 || l_rise !== 1'b0) a++;
      tick();
    end
    check("R2 fall strobe each cycle", a, 0);
    wr(32'h0001_0000);
    tick();
    check("R2 neg bit ignored fall", int'(l_fall), 1);
    check("R2 neg bit ignored rise", int'(l_rise), 0);
    wr(32'h0000_1000);
    idle = 1'b1;
    repeat (4) tick();
    check("R5 bypass idle stop", int'(card_clk), 0);
    check("R5 bypass idle strobe", int'(l_fall), 0);
    idle = 1'b0;

    // R6 flow control
    wr(32'h0002_0003);
    fifo_rdy = 1'b0;
    repeat (10) tick();
    quiet(20, a);
    check("R6 fifo stall stops clock", a, 0);
    fifo_rdy = 1'b1;
    measure(hi, lo, rs, fs);
    check("R6 resume high", hi, 3);
    wr(32'd3);
    fifo_rdy = 1'b0;
    measure(hi, lo, rs, fs);
    check("R6 fifo ignored without enable", hi, 3);
    fifo_rdy = 1'b1;

    // R7 stop during high phase
    wr(32'h0000_1006);
    measure(hi, lo, rs, fs);
    to_rise();
    idle = 1'b1;
    hi = 1;
    tick();
    while (card_clk === 1'b1 && hi < 100) begin hi++; tick(); end
    check("R7 high phase completes", hi, 6);
    quiet(20, a);
    check("R7 stays low", a, 0);
    idle = 1'b0;

    // R8 divider change mid-period
    wr(32'd3);
    measure(hi, lo, rs, fs);
    to_rise();
    wr(32'd5);
    hi = 2;
    tick();
    while (card_clk === 1'b1 && hi < 100) begin hi++; tick(); end
    check("R8 old high kept", hi, 3);
    lo = 0;
    while (card_clk === 1'b0 && lo < 100) begin lo++; tick(); end
    check("R8 new low", lo, 5);
    hi = 0;
    while (card_clk === 1'b1 && hi < 100) begin hi++; tick(); end
    check("R8 new high", hi, 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule